// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a multi-register load or store. It receives a base address, a register selection mask, an addressing mode, a load/store flag and a writeback flag. From these it produces one word access for each selected register, in order. Each access carries a word address, the index of the register it belongs to and a direction. Accesses leave through a valid/ready handshake. When the last access has been accepted, the block reports the updated base value for the register file to write back.

The block supports four addressing modes. In every mode the lowest-numbered selected register goes to the lowest address, so only the starting address and the final base value depend on the mode. The operation cannot be stopped once it has started.

Mode encoding: bit 1 selects the direction (0 = ascending, 1 = descending) and bit 0 selects whether the base is stepped before the first access (1) or not (0).

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `acc_valid_o`, `done_o` and `wb_valid_o` are all low.
- R2: Mode 2'b00 (ascending, step after) issues the first access at the base and adds 4 for each later access. With base 0x10 and three registers the writeback value is 0x1C.
- R3: Mode 2'b01 (ascending, step before) issues the first access at base+4. With base 0x10 and three registers the writeback value is 0x1C.
- R4: Mode 2'b10 (descending, step after) issues the first access at base−4·N+4, where N is the number of set mask bits. With base 0x10 and three registers this is 0x08, and the writeback value is 0x04.
- R5: Mode 2'b11 (descending, step before) issues the first access at base−4·N. With base 0x10 and three registers this is 0x04, and the writeback value is 0x04.
- R6: Accesses are presented in increasing register-index order, one for each set mask bit. `acc_write_o` is the inverse of the load flag captured at start.
- R7: `wb_value_o` equals base+4·N for ascending modes and base−4·N for descending modes, and is presented while `done_o` is high. `wb_valid_o` is high only in that cycle, and only when the writeback flag was set at start.
- R8: While `acc_valid_o` is high and `acc_ready_i` is low, address, index and direction hold steady in the next cycle.
- R9: `start_i` is accepted only while `busy_o` is low. A start raised during an operation has no effect on it.
- R10: An empty mask produces no access. `done_o` follows one cycle after the start is accepted, with `wb_value_o` equal to the (aligned) base.
- R11: The two low base bits are ignored: every address and the writeback value are multiples of 4.
- R12: `busy_o` rises the cycle after a start is accepted and stays high through the single `done_o` cycle. `done_o` follows the last handshake by one cycle. With ready held high, an operation spans 2+N cycles counting the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| base_i | input | ADDR_W | Base register value |
| reglist_i | input | NREG | Register selection mask |
| mode_i | input | 2 | Addressing mode |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_en_i | input | 1 | Request base writeback |
| busy_o | output | 1 | Operation in progress |
| acc_valid_o | output | 1 | Access request valid |
| acc_ready_i | input | 1 | Memory accepts the access |
| acc_addr_o | output | ADDR_W | Word address of the access |
| acc_idx_o | output | $clog2(NREG) | Register index of the access |
| acc_write_o | output | 1 | Access is a store |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback requested, with done |
| wb_value_o | output | ADDR_W | Updated base value |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 16-entry mask and 4-byte words. At these values the full mask of 16 registers can be exercised, and descending modes from small bases wrap around address zero. Random ready patterns, including long stalls, are applied against the full mask. A start raised during a long transfer lets the bench show that the running operation keeps its own access count.

// File: rtl/blkseq_pkg.sv
// Shared types for the block transfer sequencer.
package blkseq_pkg;
    // bit1: descending, bit0: step before first access
    typedef enum logic [1:0] {
        AM_ASC_AFTER  = 2'b00,
        AM_ASC_BEFORE = 2'b01,
        AM_DSC_AFTER  = 2'b10,
        AM_DSC_BEFORE = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_FIN  = 2'd2
    } sq_state_e;
endpackage

// File: rtl/blkseq_popcount.sv
// Counts set bits of a mask. Purely combinational.
module blkseq_popcount #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  mask_i,
    output logic [CW-1:0] cnt_o
);
    // Sum the mask bits.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(mask_i[i]);
    end
endmodule

// File: rtl/blkseq_lowbit.sv
// Returns the index of the lowest set bit; zero when the mask is empty.
module blkseq_lowbit #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask_i,
    output logic [IW-1:0] idx_o
);
    // Scan downwards so the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) if (mask_i[i]) idx_o = IW'(i);
    end
endmodule

// File: rtl/blkseq_addr_calc.sv
// Derives first access address and final base from base, count and mode.
// Assumes base is already word aligned.
module blkseq_addr_calc
    import blkseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4,
    localparam int BYTE_SH   = $clog2(WORD_BYTES)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CW-1:0]     cnt_i,
    input  amode_e            mode_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] final_o
);
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] step;

    // Total byte span and single step.
    always_comb begin
        span = ADDR_W'(cnt_i) << BYTE_SH;
        step = ADDR_W'(WORD_BYTES);
    end

    // Select first address per mode.
    always_comb begin
        unique case (mode_i)
            AM_ASC_AFTER:  first_o = base_i;
            AM_ASC_BEFORE: first_o = base_i + step;
            AM_DSC_AFTER:  first_o = base_i - span + step;
            default:       first_o = base_i - span;
        endcase
    end

    // Final base depends only on direction.
    always_comb final_o = mode_i[1] ? (base_i - span) : (base_i + span);
endmodule

// File: rtl/blk_xfer_seq.sv
// Sequencer for multi-register load/store: one word access per set mask bit,
// lowest index first at the lowest address, then a done pulse with the new base.
// Assumes the memory side honours valid/ready; reset is synchronous active-low.
module blk_xfer_seq
    import blkseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   reglist_i,
    input  logic [1:0]        mode_i,
    input  logic              load_i,
    input  logic              wb_en_i,
    output logic              busy_o,
    output logic              acc_valid_o,
    input  logic              acc_ready_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [IDX_W-1:0]  acc_idx_o,
    output logic              acc_write_o,
    output logic              done_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_value_o
);
    sq_state_e         state_q;
    logic [NREG-1:0]   mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbval_q;
    logic              write_q;
    logic              wben_q;

    logic [ADDR_W-1:0] base_al;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] final_base;
    logic [NREG-1:0]   mask_nx;
    logic              accept;
    logic              hshake;

    // Word-align the incoming base.
    always_comb base_al = base_i & ~ADDR_W'(WORD_BYTES - 1);

    blkseq_popcount #(.W(NREG)) u_cnt (.mask_i(reglist_i), .cnt_o(cnt));

    blkseq_addr_calc #(
        .ADDR_W(ADDR_W), .CW(CNT_W), .WORD_BYTES(WORD_BYTES)
    ) u_calc (
        .base_i (base_al),
        .cnt_i  (cnt),
        .mode_i (amode_e'(mode_i)),
        .first_o(first_addr),
        .final_o(final_base)
    );

    blkseq_lowbit #(.W(NREG)) u_low (.mask_i(mask_q), .idx_o(acc_idx_o));

    // Handshake qualifiers and the mask with its lowest bit removed.
    always_comb begin
        accept  = (state_q == SQ_IDLE) && start_i;
        hshake  = (state_q == SQ_XFER) && acc_ready_i;
        mask_nx = mask_q & (mask_q - NREG'(1));
    end

    // Sequencer state and operation context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            mask_q  <= '0;
            addr_q  <= '0;
            wbval_q <= '0;
            write_q <= 1'b0;
            wben_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (accept) begin
                    mask_q  <= reglist_i;
                    addr_q  <= first_addr;
                    wbval_q <= final_base;
                    write_q <= !load_i;
                    wben_q  <= wb_en_i;
                    state_q <= (reglist_i == '0) ? SQ_FIN : SQ_XFER;
                end
                SQ_XFER: if (hshake) begin
                    mask_q  <= mask_nx;
                    addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
                    if (mask_nx == '0) state_q <= SQ_FIN;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Output decode from registered state.
    always_comb begin
        busy_o      = (state_q != SQ_IDLE);
        acc_valid_o = (state_q == SQ_XFER);
        acc_addr_o  = addr_q;
        acc_write_o = write_q;
        done_o      = (state_q == SQ_FIN);
        wb_valid_o  = done_o && wben_q;
        wb_value_o  = wbval_q;
    end
endmodule

// File: rtl/blkseq_checker.sv
// Temporal checks on the sequencer ports; attached by bind below.
module blkseq_checker #(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              acc_valid_o,
    input logic              acc_ready_i,
    input logic [ADDR_W-1:0] acc_addr_o,
    input logic [IDX_W-1:0]  acc_idx_o,
    input logic              acc_write_o,
    input logic              done_o,
    input logic              wb_valid_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o && !acc_ready_i |=> acc_valid_o && $stable(acc_addr_o)
            && $stable(acc_idx_o) && $stable(acc_write_o));

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o && acc_ready_i |=> !acc_valid_o || (acc_addr_o == $past(acc_addr_o) + STEP));

    a_r6_idx_rising: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o && acc_ready_i |=> !acc_valid_o || (acc_idx_o > $past(acc_idx_o)));

    a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |-> (acc_addr_o & (STEP - 1'b1)) == '0);

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    a_r12_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_o || done_o) |-> busy_o && $onehot0({acc_valid_o, done_o}));

    a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

    a_r7_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    a_r9_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o);
endmodule

bind blk_xfer_seq blkseq_checker #(
    .ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/blk_xfer_seq_test.sv
`timescale 1ns/1ps
module blk_xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] reglist_i = '0;
    logic [1:0]  mode_i = '0;
    logic        load_i = 1'b0;
    logic        wb_en_i = 1'b0;
    logic        acc_ready_i = 1'b1;
    logic        busy_o, acc_valid_o, acc_write_o, done_o, wb_valid_o;
    logic [31:0] acc_addr_o, wb_value_o;
    logic [3:0]  acc_idx_o;

    blk_xfer_seq uut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int          m_st = 0;
    logic [31:0] aq[$];
    int          iq[$];
    logic [31:0] m_wb;
    bit          m_wbv, m_wr;
    string       m_tag = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; aq.delete(); iq.delete();
        end else begin
            case (m_st)
                0: if (start_i) begin
                    automatic int n = 0;
                    automatic logic [31:0] b = {base_i[31:2], 2'b00};
                    automatic logic [31:0] a;
                    for (int i = 0; i < 16; i++) if (reglist_i[i]) begin iq.push_back(i); n++; end
                    case (mode_i)
                        2'b00: begin a = b;             m_tag = "R2"; end
                        2'b01: begin a = b + 4;         m_tag = "R3"; end
                        2'b10: begin a = b - 4*n + 4;   m_tag = "R4"; end
                        default: begin a = b - 4*n;     m_tag = "R5"; end
                    endcase
                    for (int k = 0; k < n; k++) aq.push_back(a + 4*k);
                    m_wb  = mode_i[1] ? b - 4*n : b + 4*n;
                    m_wbv = wb_en_i;
                    m_wr  = !load_i;
                    m_st  = (n == 0) ? 2 : 1;
                end
                1: if (acc_ready_i) begin
                    void'(aq.pop_front()); void'(iq.pop_front());
                    if (aq.size() == 0) m_st = 2;
                end
                default: m_st = 0;
            endcase
        end
    end

    // ---------------- per-cycle compare and monitor ----------------
    int          hs_cnt, busy_cnt, stall_bad, stall_seen;
    logic [31:0] first_addr, seen_wb;
    bit          seen_wbv, seen_done, prev_stall;
    logic [31:0] prev_addr;
    logic [3:0]  prev_idx;

    always @(negedge clk) if (rst_n) begin
        chk(busy_o == (m_st != 0), "R12", "busy", 32'(busy_o), 32'(m_st != 0));
        chk(acc_valid_o == (m_st == 1), "R12", "valid", 32'(acc_valid_o), 32'(m_st == 1));
        chk(done_o == (m_st == 2), "R12", "done", 32'(done_o), 32'(m_st == 2));
        if (m_st == 1 && aq.size() > 0) begin
            chk(acc_addr_o == aq[0], m_tag, "addr", acc_addr_o, aq[0]);
            chk(32'(acc_idx_o) == iq[0], "R6", "idx", 32'(acc_idx_o), iq[0]);
            chk(acc_write_o == m_wr, "R6", "write", 32'(acc_write_o), 32'(m_wr));
        end
        if (m_st == 2) begin
            chk(wb_valid_o == m_wbv, "R7", "wb_valid", 32'(wb_valid_o), 32'(m_wbv));
            chk(wb_value_o == m_wb, "R7", "wb_value", wb_value_o, m_wb);
        end
        if (prev_stall && (!acc_valid_o || acc_addr_o != prev_addr || acc_idx_o != prev_idx))
            stall_bad++;
        prev_stall = acc_valid_o && !acc_ready_i;
        if (prev_stall) stall_seen++;
        prev_addr = acc_addr_o; prev_idx = acc_idx_o;
        if (busy_o) busy_cnt++;
        if (acc_valid_o && acc_ready_i) begin
            if (hs_cnt == 0) first_addr = acc_addr_o;
            hs_cnt++;
        end
        if (done_o) begin seen_done = 1; seen_wb = wb_value_o; seen_wbv = wb_valid_o; end
    end

    // ready pattern: 0 always high, 1 random, 2 long stalls
    int rdy_pat = 0, cyc = 0;
    always @(posedge clk) begin
        cyc++;
        #1 case (rdy_pat)
            0: acc_ready_i = 1'b1;
            1: acc_ready_i = 1'($urandom % 2);
            default: acc_ready_i = (cyc % 4 == 3);
        endcase
    end

    task automatic run_op(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m,
                          input bit ld, input bit wb, input bit poke);
        hs_cnt = 0; busy_cnt = 0; seen_done = 0; first_addr = 'x;
        @(posedge clk); #1;
        base_i = b; reglist_i = l; mode_i = m; load_i = ld; wb_en_i = wb; start_i = 1;
        @(posedge clk); #1;
        start_i = 0;
        if (poke) begin
            base_i = 32'h5000; reglist_i = 16'h0001; mode_i = 2'b11; start_i = 1;
            @(posedge clk); @(posedge clk); #1;
            start_i = 0;
        end
        for (int t = 0; t < 2000 && !seen_done; t++) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !acc_valid_o && !done_o && !wb_valid_o, "R1", "idle after reset",
            {busy_o, acc_valid_o, done_o, wb_valid_o}, 0);

        // four modes, base 0x10, registers 1..3
        for (int m = 0; m < 4; m++) begin
            automatic logic [31:0] ef [4] = '{32'h10, 32'h14, 32'h08, 32'h04};
            automatic logic [31:0] ew [4] = '{32'h1C, 32'h1C, 32'h04, 32'h04};
            automatic string tg [4] = '{"R2", "R3", "R4", "R5"};
            run_op(32'h10, 16'h000E, 2'(m), 1, 1, 0);
            chk(first_addr == ef[m], tg[m], "first addr", first_addr, ef[m]);
            chk(seen_wb == ew[m] && seen_wbv, tg[m], "writeback", seen_wb, ew[m]);
            chk(busy_cnt == 4, "R12", "busy cycles for N=3", busy_cnt, 4);
        end

        // store without writeback, random ready
        rdy_pat = 1;
        run_op(32'h1000, 16'h8001, 2'b11, 0, 0, 0);
        chk(!seen_wbv, "R7", "wb_valid with flag clear", 32'(seen_wbv), 0);
        chk(hs_cnt == 2, "R6", "access count", hs_cnt, 2);

        // empty list
        rdy_pat = 0;
        run_op(32'h240, 16'h0000, 2'b10, 1, 1, 0);
        chk(hs_cnt == 0, "R10", "accesses on empty list", hs_cnt, 0);
        chk(seen_wb == 32'h240, "R10", "base unchanged", seen_wb, 32'h240);
        chk(busy_cnt == 1, "R10", "done one cycle after accept", busy_cnt, 1);

        // unaligned base
        run_op(32'h13, 16'h0101, 2'b00, 1, 1, 0);
        chk(first_addr == 32'h10, "R11", "aligned first addr", first_addr, 32'h10);
        chk(seen_wb == 32'h18, "R11", "aligned writeback", seen_wb, 32'h18);

        // start raised mid-operation
        run_op(32'h800, 16'hF0F0, 2'b00, 1, 1, 1);
        chk(hs_cnt == 8, "R9", "access count unaffected by start", hs_cnt, 8);
        chk(seen_wb == 32'h820, "R9", "writeback unaffected by start", seen_wb, 32'h820);

        // long stalls on full mask
        rdy_pat = 2; stall_bad = 0; stall_seen = 0;
        run_op(32'h100, 16'hFFFF, 2'b10, 0, 1, 0);
        chk(stall_bad == 0 && stall_seen > 0, "R8", "hold under stall", stall_bad, 0);
        chk(hs_cnt == 16, "R6", "full mask count", hs_cnt, 16);

        // random operations
        rdy_pat = 1;
        for (int r = 0; r < 40; r++) begin
            automatic logic [15:0] l = 16'($urandom);
            run_op($urandom, l, 2'($urandom), 1'($urandom), 1'($urandom), 0);
            chk(hs_cnt == $countones(l), "R6", "random access count", hs_cnt, $countones(l));
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule